// File: doc/BRIEF.md
# Start/Done Statement Sequencer

This block runs a fixed, ordered program of register-transfer statements over 32-bit operands, one statement per clock cycle. The program is set at elaboration as a parameter table. Each entry holds an opcode, one destination index and three source indices. Sources are addressed in one numbering space: data inputs come first (0 to NI-1), then the output registers, then the internal registers. Destinations are numbered across the output registers and then the internal registers. Ten operators are available: copy, add, subtract, multiply, greater-than, less-than, equality, select, logical shift right and logical shift left.

The controller has one state vector of the fewest bits that can encode Wait, one state per statement (Step 0 to Step NS-1) and Final. The transitions are:
- Wait to Step 0 when `start` is 1.
- Wait to Wait when `start` is 0.
- Step k to Step k+1.
- The last Step to Final.
- Final to Wait.
- Any state to Wait when `rst` is sampled high.

A parent block sets the data inputs, pulses `start`, and takes the outputs once `done` has pulsed. The outputs keep their values until the next run or reset.

Top module: `stmt_seq`

## Requirements
- R1: While `rst` is high at a rising clock edge, every output register and internal register clears to 0, `done` clears to 0 and the controller returns to Wait. This holds in any state, including partway through a run.
- R2: In Wait with `start` low, the state does not change and the outputs hold their values, even when the data inputs change.
- R3: Statements run in table order, one per cycle. Take the edge that samples `start` in Wait as edge 0. The result of statement k is visible at the outputs after edge k+1.
- R4: `done` is 1 for exactly one cycle, in Final, right after edge NS. At every other time it is 0. Final always moves to Wait on the next edge.
- R5: `start` has no effect while the controller is in a Step state or in Final.
- R6: Add, subtract and multiply give the low 32 bits of the result, so they wrap modulo 2^32.
- R7: Greater-than, less-than and equality treat operands as unsigned. They write a 32-bit 1 when true and 0 when false.
- R8: Select (source a ? source b : source c) takes source b when source a is any nonzero value and source c otherwise.
- R9: The shifts are logical. The amount is the full 32-bit source b, and an amount of 32 or more gives 0.
- R10: Copy writes source a unchanged to the destination.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Starts a run when the controller is in Wait |
| done | output | 1 | Registered one-cycle pulse while in Final |
| data_in | input | NI x 32 | Data inputs, index 0 first |
| data_out | output | NO x 32 | Output registers, index 0 first |

## Verification
A wrong state vector shows at the ports quickly. If a state is skipped or repeated, `done` arrives one or more edges away from edge NS. If a Step state decodes the wrong statement, an output register holds a wrong value from the next edge onward, and that value stays in place until the next run. The default program sends every operator into one of four outputs: select switches between the less-than and equality results, and copy exposes a shift round-trip. A single run with chosen inputs therefore reaches every path. A `start` that is wrongly accepted, or a Final that does not return to Wait, shows up as an extra or missing `done` pulse within NS+2 cycles.

// File: rtl/stmt_seq_pkg.sv
package stmt_seq_pkg;

    localparam int IDX_W = 8;

    typedef enum logic [3:0] {
        OP_COPY = 4'd0,
        OP_ADD  = 4'd1,
        OP_SUB  = 4'd2,
        OP_MUL  = 4'd3,
        OP_GT   = 4'd4,
        OP_LT   = 4'd5,
        OP_EQ   = 4'd6,
        OP_SEL  = 4'd7,
        OP_SHR  = 4'd8,
        OP_SHL  = 4'd9
    } op_e;

    typedef enum logic [1:0] {
        PH_WAIT,
        PH_STEP,
        PH_FINAL
    } phase_e;

    // dst: writable index (outputs, then internal registers)
    // src_*: operand index (inputs, then outputs, then internal registers)
    typedef struct packed {
        op_e              op;
        logic [IDX_W-1:0] dst;
        logic [IDX_W-1:0] src_a;
        logic [IDX_W-1:0] src_b;
        logic [IDX_W-1:0] src_c;
    } stmt_t;

    // Default program: inputs a=0 b=1 c=2; outputs y0..y3 = src 3..6,
    // dst 0..3; internal d = src 7 / dst 4, e = src 8 / dst 5.
    localparam stmt_t DEMO_PROG [10] = '{
        '{OP_ADD,  8'd4, 8'd0, 8'd1, 8'd0},  // d  = a + b
        '{OP_SUB,  8'd5, 8'd0, 8'd1, 8'd0},  // e  = a - b
        '{OP_MUL,  8'd0, 8'd7, 8'd8, 8'd0},  // y0 = d * e
        '{OP_LT,   8'd4, 8'd0, 8'd1, 8'd0},  // d  = a < b
        '{OP_EQ,   8'd5, 8'd0, 8'd2, 8'd0},  // e  = a == c
        '{OP_SEL,  8'd1, 8'd2, 8'd7, 8'd8},  // y1 = c ? d : e
        '{OP_SHL,  8'd4, 8'd0, 8'd2, 8'd0},  // d  = a << c
        '{OP_SHR,  8'd5, 8'd7, 8'd2, 8'd0},  // e  = d >> c
        '{OP_GT,   8'd2, 8'd0, 8'd8, 8'd0},  // y2 = a > e
        '{OP_COPY, 8'd3, 8'd8, 8'd0, 8'd0}   // y3 = e
    };

endpackage

// File: rtl/stmt_seq_alu.sv
module stmt_seq_alu
    import stmt_seq_pkg::*;
#(
    parameter int DW = 32
) (
    input  op_e           op,
    input  logic [DW-1:0] va,
    input  logic [DW-1:0] vb,
    input  logic [DW-1:0] vc,
    output logic [DW-1:0] res
);

    localparam logic [DW-1:0] SH_LIMIT = DW'(DW);
    localparam logic [DW-1:0] ONE      = DW'(1);

    logic shift_out;
    assign shift_out = (vb >= SH_LIMIT);

    always_comb begin
        unique case (op)
            OP_COPY: res = va;
            OP_ADD:  res = va + vb;
            OP_SUB:  res = va - vb;
            OP_MUL:  res = va * vb;
            OP_GT:   res = (va > vb)  ? ONE : '0;
            OP_LT:   res = (va < vb)  ? ONE : '0;
            OP_EQ:   res = (va == vb) ? ONE : '0;
            OP_SEL:  res = (va != '0) ? vb : vc;
            OP_SHR:  res = shift_out ? '0 : (va >> vb);
            OP_SHL:  res = shift_out ? '0 : (va << vb);
            default: res = '0;
        endcase
    end

endmodule

// File: rtl/stmt_seq_regs.sv
module stmt_seq_regs
    import stmt_seq_pkg::*;
#(
    parameter int DW = 32,
    parameter int NW = 6
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   we,
    input  logic [IDX_W-1:0]       wsel,
    input  logic [DW-1:0]          wdata,
    output logic [NW-1:0][DW-1:0]  q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (we) begin
            for (int k = 0; k < NW; k++) begin
                if (wsel == IDX_W'(k)) q[k] <= wdata;
            end
        end
    end

    // R1: reset clears every held register
    a_r1_regs_cleared: assert property (@(posedge clk)
        rst |=> (q == '0));

    // R2: without a statement write nothing changes
    a_r2_regs_hold: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(q));

endmodule

// File: rtl/stmt_seq_ctrl.sv
module stmt_seq_ctrl
    import stmt_seq_pkg::*;
#(
    parameter int NS = 10,
    localparam int SW  = $clog2(NS + 2),
    localparam int STW = (NS > 1) ? $clog2(NS) : 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    output logic           exec,
    output logic [STW-1:0] step,
    output logic           done
);

    localparam logic [SW-1:0] ST_WAIT  = '0;
    localparam logic [SW-1:0] ST_FIRST = SW'(1);
    localparam logic [SW-1:0] ST_LAST  = SW'(NS);
    localparam logic [SW-1:0] ST_FINAL = SW'(NS + 1);

    logic [SW-1:0] state;
    logic [SW-1:0] state_m1;
    phase_e        phase;

    always_comb begin
        if (state == ST_WAIT)       phase = PH_WAIT;
        else if (state == ST_FINAL) phase = PH_FINAL;
        else                        phase = PH_STEP;
    end

    // The single clocked process of the controller: state and done.
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_WAIT;
            done  <= 1'b0;
        end else begin
            unique case (phase)
                PH_WAIT: begin
                    done <= 1'b0;
                    if (start) state <= ST_FIRST;
                end
                PH_STEP: begin
                    state <= state + SW'(1);
                    done  <= (state == ST_LAST);
                end
                PH_FINAL: begin
                    state <= ST_WAIT;
                    done  <= 1'b0;
                end
            endcase
        end
    end

    assign state_m1 = state - SW'(1);
    assign step     = state_m1[STW-1:0];
    assign exec     = (phase == PH_STEP);

    // R1: reset returns to Wait with done low
    a_r1_ctrl_reset: assert property (@(posedge clk)
        rst |=> (state == ST_WAIT && !done));

    // R2: Wait holds while start is low
    a_r2_wait_holds: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_WAIT && !start) |=> (state == ST_WAIT));

    // R3: each statement state lasts one cycle and leads to the next
    a_r3_one_step: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_STEP) |=> (state == $past(state) + SW'(1)));

    // R4: done only in Final, never two cycles running
    a_r4_done_in_final: assert property (@(posedge clk) disable iff (rst)
        done |-> (state == ST_FINAL));
    a_r4_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    a_r4_final_to_wait: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_FINAL) |=> (state == ST_WAIT));

    // R5: outside Wait, start never re-enters the first statement
    a_r5_start_ignored: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_WAIT) |=> (state != ST_FIRST));

endmodule

// File: rtl/stmt_seq.sv
module stmt_seq
    import stmt_seq_pkg::*;
#(
    parameter int    DW = 32,
    parameter int    NI = 3,
    parameter int    NO = 4,
    parameter int    NR = 2,
    parameter int    NS = 10,
    parameter stmt_t PROG [NS] = DEMO_PROG,
    localparam int   NW   = NO + NR,
    localparam int   NSRC = NI + NW,
    localparam int   STW  = (NS > 1) ? $clog2(NS) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    output logic                  done,
    input  logic [NI-1:0][DW-1:0] data_in,
    output logic [NO-1:0][DW-1:0] data_out
);

    logic                    exec;
    logic [STW-1:0]          step;
    stmt_t                   cur;
    logic [NW-1:0][DW-1:0]   rf_q;
    logic [NSRC-1:0][DW-1:0] opnd;
    logic [DW-1:0]           va, vb, vc, alu_res;

    function automatic logic [DW-1:0] pick(input logic [IDX_W-1:0] idx,
                                           input logic [NSRC-1:0][DW-1:0] v);
        logic [DW-1:0] r;
        r = '0;
        for (int k = 0; k < NSRC; k++) begin
            if (idx == IDX_W'(k)) r = v[k];
        end
        return r;
    endfunction

    stmt_seq_ctrl #(.NS(NS)) i_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .exec  (exec),
        .step  (step),
        .done  (done)
    );

    assign cur  = exec ? PROG[step] : '0;
    assign opnd = {rf_q, data_in};
    assign va   = pick(cur.src_a, opnd);
    assign vb   = pick(cur.src_b, opnd);
    assign vc   = pick(cur.src_c, opnd);

    stmt_seq_alu #(.DW(DW)) i_alu (
        .op  (cur.op),
        .va  (va),
        .vb  (vb),
        .vc  (vc),
        .res (alu_res)
    );

    stmt_seq_regs #(.DW(DW), .NW(NW)) i_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (exec),
        .wsel  (cur.dst),
        .wdata (alu_res),
        .q     (rf_q)
    );

    generate
        for (genvar g = 0; g < NO; g++) begin : g_out
            assign data_out[g] = rf_q[g];
        end
    endgenerate

    // R7: a comparison statement writes only 0 or 1
    a_r7_bool_result: assert property (@(posedge clk) disable iff (rst)
        (exec && (cur.op == OP_GT || cur.op == OP_LT || cur.op == OP_EQ))
        |-> (alu_res[DW-1:1] == '0));

    // R9: an amount of DW or more empties the shifted value
    a_r9_wide_shift: assert property (@(posedge clk) disable iff (rst)
        (exec && (cur.op == OP_SHR || cur.op == OP_SHL) && vb >= DW'(DW))
        |-> (alu_res == '0));

endmodule

// File: tb/test_stmt_seq.sv
module test_stmt_seq;

    localparam int CLK_PERIOD = 10;
    localparam int NI = 3;
    localparam int NO = 4;
    localparam int NS = 10;
    localparam int NV = 9;

    // stimulus rows: a, b, c
    localparam logic [31:0] VEC [NV][3] = '{
        '{32'd5,          32'd3,          32'd1},
        '{32'd3,          32'd7,          32'd2},
        '{32'd0,          32'd9,          32'd0},
        '{32'd5,          32'd5,          32'd0},
        '{32'h8000_0001,  32'd1,          32'd4},
        '{32'hFFFF_FFFF,  32'd2,          32'd31},
        '{32'h0000_1234,  32'd1,          32'd32},
        '{32'd7,          32'd1,          32'd40},
        '{32'h0001_0000,  32'h0001_0000,  32'd0}
    };

    logic                  clk = 1'b0;
    logic                  rst;
    logic                  start;
    logic                  done;
    logic [NI-1:0][31:0]   din;
    logic [NO-1:0][31:0]   dout;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    stmt_seq i_stmt_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .done     (done),
        .data_in  (din),
        .data_out (dout)
    );

    // Expected outputs of the default program, from R6 to R10
    function automatic logic [NO-1:0][31:0] model(input logic [31:0] a,
                                                  input logic [31:0] b,
                                                  input logic [31:0] c);
        logic [31:0] d, e, y0, y1, y2, y3;
        d  = a + b;
        e  = a - b;
        y0 = d * e;
        d  = (a < b)  ? 32'd1 : 32'd0;
        e  = (a == c) ? 32'd1 : 32'd0;
        y1 = (c != 0) ? d : e;
        d  = (c >= 32) ? 32'd0 : (a << c);
        e  = (c >= 32) ? 32'd0 : (d >> c);
        y2 = (a > e)  ? 32'd1 : 32'd0;
        y3 = e;
        return {y3, y2, y1, y0};
    endfunction

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    // Pulse start for one edge, then count edges until done is seen.
    task automatic run_prog(output int lat);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        lat = 0;
        while (!done && lat < 50) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic watch_no_done(input string req, input int cycles);
        int seen;
        seen = 0;
        for (int k = 0; k < cycles; k++) begin
            @(negedge clk);
            if (done) seen++;
        end
        check(req, 32'(seen), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

    initial begin
        int lat;
        logic [NO-1:0][31:0] exp;
        logic [NO-1:0][31:0] held;

        rst   = 1'b1;
        start = 1'b0;
        din   = {32'd9, 32'd8, 32'd7};
        repeat (2) @(negedge clk);
        // R1: reset state
        check("R1 reset outputs", 32'(dout == '0), 32'd1);
        check("R1 reset done", 32'(done), 32'd0);
        rst = 1'b0;

        // R2: no start, inputs move, nothing happens
        din = {32'd1, 32'd2, 32'd3};
        watch_no_done("R2 no done without start", 6);
        check("R2 outputs hold in Wait", 32'(dout == '0), 32'd1);

        // R3: timing of one statement result (y0 written by statement 2)
        din = {VEC[0][2], VEC[0][1], VEC[0][0]};
        exp = model(VEC[0][0], VEC[0][1], VEC[0][2]);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;          // after edge 0
        @(negedge clk);                       // after edge 1
        @(negedge clk);                       // after edge 2
        check("R3 y0 before its edge", dout[0], 32'd0);
        @(negedge clk);                       // after edge 3
        check("R3 y0 after edge 3", dout[0], exp[0]);
        lat = 3;
        while (!done && lat < 50) begin
            @(negedge clk);
            lat++;
        end
        check("R4 done after edge NS", 32'(lat), 32'(NS));
        @(negedge clk);
        check("R4 done one cycle", 32'(done), 32'd0);

        // Table walk: R4, R6, R7, R8, R9, R10
        for (int v = 0; v < NV; v++) begin
            din = {VEC[v][2], VEC[v][1], VEC[v][0]};
            exp = model(VEC[v][0], VEC[v][1], VEC[v][2]);
            run_prog(lat);
            check($sformatf("R4 latency vec%0d", v), 32'(lat), 32'(NS));
            check($sformatf("R6 y0 add/sub/mul vec%0d", v), dout[0], exp[0]);
            check($sformatf("R8 y1 select lt/eq vec%0d", v), dout[1], exp[1]);
            check($sformatf("R7 y2 compare vec%0d", v), dout[2], exp[2]);
            check($sformatf("R9 R10 y3 shift copy vec%0d", v), dout[3], exp[3]);
            @(negedge clk);
            check($sformatf("R4 done falls vec%0d", v), 32'(done), 32'd0);
        end

        // R2: inputs change while idle, outputs hold
        held = dout;
        din  = {32'd11, 32'd22, 32'd33};
        repeat (5) @(negedge clk);
        check("R2 outputs stable when idle", 32'(dout == held), 32'd1);

        // R5: start pulsed mid-run and during Final
        din = {VEC[4][2], VEC[4][1], VEC[4][0]};
        exp = model(VEC[4][0], VEC[4][1], VEC[4][2]);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        lat = 0;
        while (!done && lat < 50) begin
            @(negedge clk);
            lat++;
            start = (lat == 3);
        end
        start = 1'b0;
        check("R5 mid-run start keeps latency", 32'(lat), 32'(NS));
        start = 1'b1;                         // sampled while in Final
        @(negedge clk) start = 1'b0;
        check("R5 done single with start in Final", 32'(done), 32'd0);
        watch_no_done("R5 no extra run", NS + 4);
        check("R5 outputs match single run", 32'(dout == exp), 32'd1);

        // R1: reset partway through a run
        din = {VEC[1][2], VEC[1][1], VEC[1][0]};
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b1;
        @(negedge clk) rst = 1'b0;
        check("R1 mid-run reset outputs", 32'(dout == '0), 32'd1);
        check("R1 mid-run reset done", 32'(done), 32'd0);
        watch_no_done("R1 back in Wait after reset", NS + 4);
        check("R1 outputs stay cleared", 32'(dout == '0), 32'd1);

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule